// File: doc/BRIEF.md
# DDR2 Command-to-Data Latency Scheduler

This block sits inside a DDR2 memory controller, downstream of the command arbiter. Each time a READ or WRITE column command goes out on the memory bus, the scheduler works out, clock by clock, when that command's data phase begins and ends. It drives three enables to the physical layer. One tells it to capture read data, one tells it to drive write data and the write mask, and one turns on the data strobe, with a preamble clock ahead of each burst.

Latency is set by three configuration inputs that play the role of mode register fields: CAS latency, posted-CAS additive latency and burst length. Read latency is the sum of additive latency and CAS latency, and write latency is one clock less. Reads and writes each run through a separate future-schedule shift register, so several bursts can be in flight at once. Bursts issued at the burst spacing join without a gap. A command whose data window would collide with one already scheduled is refused and reported.

Top module: `ddr2_lat_sched`

## Requirements
- R1: While reset is held and on the first clock after it, every output is low.
- R2: For a READ sampled at clock edge E, the read capture enable is high for the clocks that follow edges E+RL through E+RL+N-1. Here RL = additive latency + CAS latency, and N is burst length divided by two.
- R3: For a WRITE sampled at edge E, the write drive enable and the write mask enable are both high after edges E+RL-1 through E+RL+N-2, with identical timing.
- R4: The CAS latency input accepts the binary values 3, 4, 5 and 6 (clocks). The additive latency input accepts the binary values 0 to 4 (clocks). Each value sets the latency in R2 and R3.
- R5: When the burst select input is 1, bursts are 8 beats long (N = 4 clocks). When it is 0, bursts are 4 beats long (N = 2 clocks).
- R6: The strobe enable rises one clock before each data window opens, stays high through the last clock of the window, and falls afterwards unless another window or preamble follows.
- R7: Commands of the same direction issued N clocks apart give one continuous enable with no gap. A WRITE followed N-1 clocks later by a READ gives back-to-back write and read windows.
- R8: A command whose data window would overlap any scheduled read or write window is dropped and produces no data window. The error output pulses high for the one clock that follows the edge that sampled it.
- R9: Configuration may change only while nothing is scheduled. The next command then uses the new latency and burst length.
- R10: The read capture enable and the write drive enable are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; commands are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas_lat | input | 3 | CAS latency in clocks (3 to 6) |
| cfg_add_lat | input | 3 | Additive latency in clocks (0 to 4) |
| cfg_burst8 | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| cmd_valid | input | 1 | A column command is issued this clock |
| cmd_is_wr | input | 1 | 1 for WRITE, 0 for READ |
| rd_capture_en | output | 1 | Read data capture window |
| wr_drive_en | output | 1 | Write data drive window |
| wr_mask_en | output | 1 | Write data mask drive window, timed like write data |
| dqs_en | output | 1 | Data strobe enable including preamble |
| proto_err | output | 1 | One-clock pulse for a refused, overlapping command |

## Verification
The bench builds the block with its default 16-entry schedule depth. That depth covers the longest read latency of 10 clocks plus an 8-beat burst and its strobe tail, so every CAS latency, additive latencies 0, 2 and 4, and both burst lengths can be swept with one read and one write per setting. At that depth, bursts packed back to back, a write turning around into a read, and read-read and read-write collisions can all be exercised against a bench-side model of the window timing.

// File: rtl/ddr2_lat_pkg.sv
package ddr2_lat_pkg;

    localparam int SCHED_DEPTH = 16;
    localparam int CL_W        = 3;
    localparam int AL_W        = 3;
    localparam int DIR_COUNT   = 2;

    typedef struct packed {
        logic [CL_W-1:0] cas_lat;
        logic [AL_W-1:0] add_lat;
        logic            long_burst;
    } lat_cfg_t;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    function automatic int burst_clocks(input logic long_burst);
        return long_burst ? 4 : 2;
    endfunction

endpackage

// File: rtl/ddr2_lat_calc.sv
module ddr2_lat_calc
    import ddr2_lat_pkg::*;
#(
    parameter int DEPTH = SCHED_DEPTH
) (
    input  lat_cfg_t         cfg,
    output logic [DEPTH-1:0] rd_data_win,
    output logic [DEPTH-1:0] rd_dqs_win,
    output logic [DEPTH-1:0] wr_data_win,
    output logic [DEPTH-1:0] wr_dqs_win
);

    int rd_lat;
    int wr_lat;
    int span;

    function automatic logic [DEPTH-1:0] win(input int first, input int len);
        logic [DEPTH-1:0] v;
        v = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i >= first && i < first + len) v[i] = 1'b1;
        end
        return v;
    endfunction

    always_comb begin
        rd_lat      = int'(cfg.add_lat) + int'(cfg.cas_lat);
        wr_lat      = rd_lat - 1;
        span        = burst_clocks(cfg.long_burst);
        rd_data_win = win(rd_lat, span);
        rd_dqs_win  = win(rd_lat - 1, span + 1);
        wr_data_win = win(wr_lat, span);
        wr_dqs_win  = win(wr_lat - 1, span + 1);
    end

endmodule

// File: rtl/ddr2_sched_pipe.sv
module ddr2_sched_pipe
    import ddr2_lat_pkg::*;
#(
    parameter int DEPTH = SCHED_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DEPTH-1:0] data_win,
    input  logic [DEPTH-1:0] dqs_win,
    output logic             data_en,
    output logic             dqs_en,
    output logic [DEPTH-1:0] data_ahead,
    output logic             busy
);

    logic [DEPTH-1:0] data_q;
    logic [DEPTH-1:0] dqs_q;

    assign data_ahead = data_q >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dqs_q  <= '0;
        end else begin
            data_q <= (data_q >> 1) | (load ? data_win : '0);
            dqs_q  <= (dqs_q  >> 1) | (load ? dqs_win  : '0);
        end
    end

    assign data_en = data_q[0];
    assign dqs_en  = dqs_q[0];
    assign busy    = (|data_q) | (|dqs_q);

    // R6
    preamble_before_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_en) |-> $past(dqs_en));

    // R6
    strobe_covers_window_chk: assert property (@(posedge clk) disable iff (rst)
        data_en |-> dqs_en);

endmodule

// File: rtl/ddr2_lat_sched.sv
module ddr2_lat_sched
    import ddr2_lat_pkg::*;
#(
    parameter int DEPTH = SCHED_DEPTH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CL_W-1:0] cfg_cas_lat,
    input  logic [AL_W-1:0] cfg_add_lat,
    input  logic            cfg_burst8,
    input  logic            cmd_valid,
    input  logic            cmd_is_wr,
    output logic            rd_capture_en,
    output logic            wr_drive_en,
    output logic            wr_mask_en,
    output logic            dqs_en,
    output logic            proto_err
);

    lat_cfg_t         cfg;
    logic [DEPTH-1:0] data_win [DIR_COUNT];
    logic [DEPTH-1:0] dqs_win  [DIR_COUNT];
    logic [DEPTH-1:0] ahead    [DIR_COUNT];
    logic             data_en  [DIR_COUNT];
    logic             strobe   [DIR_COUNT];
    logic             busy     [DIR_COUNT];
    logic [DEPTH-1:0] new_win;
    logic             clash;
    logic             accept;
    dir_e             cmd_dir;

    assign cfg     = '{cas_lat: cfg_cas_lat, add_lat: cfg_add_lat, long_burst: cfg_burst8};
    assign cmd_dir = cmd_is_wr ? DIR_WR : DIR_RD;

    ddr2_lat_calc #(.DEPTH(DEPTH)) calc_i (
        .cfg         (cfg),
        .rd_data_win (data_win[DIR_RD]),
        .rd_dqs_win  (dqs_win[DIR_RD]),
        .wr_data_win (data_win[DIR_WR]),
        .wr_dqs_win  (dqs_win[DIR_WR])
    );

    assign new_win = data_win[cmd_dir];
    assign clash   = cmd_valid && |(new_win & (ahead[DIR_RD] | ahead[DIR_WR]));
    assign accept  = cmd_valid && !clash;

    for (genvar g = 0; g < DIR_COUNT; g++) begin : g_dir
        ddr2_sched_pipe #(.DEPTH(DEPTH)) pipe_i (
            .clk        (clk),
            .rst        (rst),
            .load       (accept && (cmd_dir == dir_e'(g))),
            .data_win   (data_win[g]),
            .dqs_win    (dqs_win[g]),
            .data_en    (data_en[g]),
            .dqs_en     (strobe[g]),
            .data_ahead (ahead[g]),
            .busy       (busy[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) proto_err <= 1'b0;
        else     proto_err <= clash;
    end

    assign rd_capture_en = data_en[DIR_RD];
    assign wr_drive_en   = data_en[DIR_WR];
    assign wr_mask_en    = data_en[DIR_WR];
    assign dqs_en        = strobe[DIR_RD] | strobe[DIR_WR];

    // R10
    no_dir_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_capture_en && wr_drive_en));

    // R8
    err_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $past(cmd_valid));

    // R9
    cfg_frozen_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        (busy[DIR_RD] || busy[DIR_WR]) |-> $stable(cfg));

    // R4
    cfg_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_cas_lat >= 3 && cfg_cas_lat <= 6 && cfg_add_lat <= 4));

endmodule

// File: tb/ddr2_lat_sched_tb_top.sv
module ddr2_lat_sched_tb_top;

    localparam int HORIZON = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_cas_lat = 3'd3;
    logic [2:0] cfg_add_lat = 3'd0;
    logic       cfg_burst8 = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_is_wr = 1'b0;
    logic       rd_capture_en, wr_drive_en, wr_mask_en, dqs_en, proto_err;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string phase = "R1";

    bit exp_rd  [HORIZON];
    bit exp_wr  [HORIZON];
    bit exp_dqs [HORIZON];
    int err_q [$];

    ddr2_lat_sched dut_i (
        .clk, .rst, .cfg_cas_lat, .cfg_add_lat, .cfg_burst8,
        .cmd_valid, .cmd_is_wr, .rd_capture_en, .wr_drive_en,
        .wr_mask_en, .dqs_en, .proto_err
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc++;

    task automatic check(input bit act, input bit exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] cyc=%0d actual=%0b expected=%0b", req, phase, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // monitor: compare outputs away from the rising edge
    always @(negedge clk) begin
        if (!done && cyc < HORIZON) begin
            bit exp_err;
            exp_err = (err_q.size() > 0 && err_q[0] == cyc);
            if (exp_err) void'(err_q.pop_front());
            check(rd_capture_en, exp_rd[cyc],  "R2");
            check(wr_drive_en,   exp_wr[cyc],  "R3");
            check(wr_mask_en,    exp_wr[cyc],  "R3");
            check(dqs_en,        exp_dqs[cyc], "R6");
            check(proto_err,     exp_err,      "R8");
            check(rd_capture_en && wr_drive_en, 1'b0, "R10");
        end
    end

    // driver: called at a falling edge, issues one command and models its window
    task automatic issue(input bit wr);
        int e, st, len;
        bit hit;
        e   = cyc + 1;
        st  = e + int'(cfg_add_lat) + int'(cfg_cas_lat) - (wr ? 1 : 0);
        len = cfg_burst8 ? 4 : 2;
        hit = 1'b0;
        for (int i = st; i < st + len; i++) if (exp_rd[i] || exp_wr[i]) hit = 1'b1;
        if (hit) begin
            err_q.push_back(e);
        end else begin
            for (int i = st; i < st + len; i++) begin
                if (wr) exp_wr[i] = 1'b1;
                else    exp_rd[i] = 1'b1;
            end
            for (int i = st - 1; i < st + len; i++) exp_dqs[i] = 1'b1;
        end
        cmd_valid = 1'b1;
        cmd_is_wr = wr;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int cl, input int al, input bit b8);
        cfg_cas_lat = 3'(cl);
        cfg_add_lat = 3'(al);
        cfg_burst8  = b8;
    endtask

    initial begin
        #600000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog [%s] cyc=%0d actual=running expected=finished", phase, cyc);
        finish_run();
    end

    initial begin
        // R1: reset state observed by the monitor
        idle(3);
        rst = 1'b0;
        idle(2);

        // R4 R5 R9: latency sweep, configuration changed only when idle
        phase = "R4 R5 R9 sweep";
        for (int cl = 3; cl <= 6; cl++) begin
            for (int al = 0; al <= 4; al += 2) begin
                for (int b = 0; b < 2; b++) begin
                    set_cfg(cl, al, b[0]);
                    idle(1);
                    issue(1'b0);
                    idle(15);
                    issue(1'b1);
                    idle(15);
                end
            end
        end

        // R7: seamless back-to-back bursts
        phase = "R7 reads BL8";
        set_cfg(4, 1, 1'b1);
        idle(1);
        issue(1'b0); idle(3);
        issue(1'b0); idle(3);
        issue(1'b0); idle(20);

        phase = "R7 writes BL4";
        set_cfg(3, 2, 1'b0);
        idle(1);
        issue(1'b1); idle(1);
        issue(1'b1); idle(1);
        issue(1'b1); idle(20);

        phase = "R7 write then read";
        issue(1'b1);
        issue(1'b0);
        idle(20);

        // R8: colliding commands are refused
        phase = "R8 read read";
        issue(1'b0);
        issue(1'b0);
        idle(20);

        phase = "R8 read write";
        issue(1'b0);
        issue(1'b1);
        idle(20);

        phase = "R8 recovery";
        issue(1'b0);
        idle(20);

        finish_run();
    end

endmodule